// File: doc/BRIEF.md
# Line Fetcher with Next-Line Prediction

This block runs the front of an instruction supply path. It keeps a current line address, issues a single read for that line to memory, and waits for the data. When the matching line comes back it passes it downstream as a bundle. The bundle carries the current generation tag, the line address, the line data and a guess of which line comes next. The fetcher then moves to that guess and issues the next read. At most one read is in flight at any time.

The guess comes from a small direct-mapped table that maps a line to its successor. The table is trained by the restart input. A restart gives the line that was being executed (`restartPrevLine`), where execution actually went (`restartNewLine`) and a fresh generation tag. A restart to a different, non-adjacent line records that jump. A restart to the same line or to the next line erases a stale entry for the previous line. A restart also drops the read in flight. Any response that later arrives for the dropped read is filtered out by its line address, or discarded because no read is pending.

Top module: `lineFetcher`

## Requirements
- R1: After a read is accepted (`cmdValid` and `cmdReady` both high), `cmdValid` stays low until the bundle for that read has been accepted or a restart has been taken.
- R2: `cmdValid` is high exactly when no read is pending and `restartValid` is low. `cmdLine` always shows the current line address.
- R3: A response produces a bundle in the same cycle only if a read is pending, `rspLine` equals the requested line and no restart is present. The bundle carries the current generation, the requested line and `rspData` unchanged.
- R4: `bndNextLine` is the table target when the table holds a valid entry for the current line. Otherwise it is the current line plus one, wrapping modulo 2^LINE_W. Once the bundle is accepted, the next read is issued for that line.
- R5: A restart loads the generation and the current line from the restart fields and cancels any pending read. During the restart cycle `cmdValid` and `bndValid` are low.
- R6: A restart where the new line is neither the previous line nor the previous line plus one stores previous→new in the table. The entry slot is the low log2(TBL_ENTRIES) bits of the previous line (bits 3:0 by default), and a lookup hits only when the remaining upper bits match in full.
- R7: A restart where the new line equals the previous line, or the previous line plus one, invalidates the entry for the previous line. It leaves alone an entry in that slot that belongs to a different line.
- R8: A response that arrives while no read is pending, or whose line does not match the pending read, is consumed (`rspReady` high) and produces no bundle.
- R9: While a matching bundle is stalled by `bndReady` low, `rspReady` is low and the read stays pending.
- R10: After reset the generation is 0, the current line is 0, no read is pending and the table is empty. `cmdValid` is therefore high with `cmdLine` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | output | 1 | Read request valid |
| cmdReady | input | 1 | Memory accepts the read request |
| cmdLine | output | LINE_W | Line address to read |
| rspValid | input | 1 | Memory response valid |
| rspReady | output | 1 | Response consumed this cycle |
| rspLine | input | LINE_W | Line address of the response |
| rspData | input | DATA_W | Line data of the response |
| bndValid | output | 1 | Bundle valid |
| bndReady | input | 1 | Downstream accepts the bundle |
| bndGen | output | GEN_W | Generation tag of the bundle |
| bndLine | output | LINE_W | Line address of the bundle |
| bndNextLine | output | LINE_W | Predicted next line |
| bndData | output | DATA_W | Line data of the bundle |
| restartValid | input | 1 | Restart request |
| restartGen | input | GEN_W | New generation tag |
| restartPrevLine | input | LINE_W | Line that was executing when the restart was raised |
| restartNewLine | input | LINE_W | Line execution continues at |

## Verification
The bundle path is combinational from the response, so bundle fields and `rspReady` are checked in the same cycle the response is driven, a short settle after the falling edge. A new command, a restart's effect on `cmdLine` and `bndGen`, and a table update all appear one clock edge after the cycle that caused them. The bench therefore checks them at the falling edge after that clock edge. Table behaviour is checked through `bndNextLine` on the next fetch of the trained line, including slot aliasing, both kinds of erase, address wrap, and a sweep that trains and then reads back every slot.

// File: rtl/fetchPkg.sv
package fetchPkg;
  // control-to-datapath strobes, all valid for a single cycle
  typedef struct packed {
    logic takeRestart;  // load generation and line from the restart fields, train table
    logic advance;      // bundle accepted: move to the predicted line
    logic issue;        // read request accepted by memory
  } fetchStrobeT;
endpackage

// File: rtl/nextLineTable.sv
module nextLineTable #(
  parameter int LINE_W      = 16,
  parameter int TBL_ENTRIES = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [LINE_W-1:0] lookupLine,
  output logic              hit,
  output logic [LINE_W-1:0] target,
  input  logic              trainEn,
  input  logic [LINE_W-1:0] trainPrev,
  input  logic [LINE_W-1:0] trainNew
);
  localparam int IDX_W = $clog2(TBL_ENTRIES);
  localparam int TAG_W = LINE_W - IDX_W;
  localparam logic [LINE_W-1:0] ONE = LINE_W'(1);

  logic [TBL_ENTRIES-1:0] validQ;
  logic [TAG_W-1:0]       tagQ [TBL_ENTRIES];
  logic [LINE_W-1:0]      tgtQ [TBL_ENTRIES];

  logic [IDX_W-1:0] rdIdx, wrIdx;
  logic [TAG_W-1:0] rdTag, wrTag;
  logic             sequential, wrMatch;

  always_comb begin
    rdIdx      = lookupLine[IDX_W-1:0];
    rdTag      = lookupLine[LINE_W-1:IDX_W];
    wrIdx      = trainPrev[IDX_W-1:0];
    wrTag      = trainPrev[LINE_W-1:IDX_W];
    sequential = (trainNew == trainPrev) || (trainNew == trainPrev + ONE);
    wrMatch    = validQ[wrIdx] && (tagQ[wrIdx] == wrTag);
    hit        = validQ[rdIdx] && (tagQ[rdIdx] == rdTag);
    target     = tgtQ[rdIdx];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ <= '0;
      for (int e = 0; e < TBL_ENTRIES; e++) begin
        tagQ[e] <= '0;
        tgtQ[e] <= '0;
      end
    end else if (trainEn) begin
      if (sequential) begin
        if (wrMatch) validQ[wrIdx] <= 1'b0;
      end else begin
        validQ[wrIdx] <= 1'b1;
        tagQ[wrIdx]   <= wrTag;
        tgtQ[wrIdx]   <= trainNew;
      end
    end
  end

  // R6: a non-adjacent redirect leaves a valid entry in its slot
  assert_train_stores_R6: assert property (@(posedge clk) disable iff (!rstN)
    (trainEn && !sequential) |=> validQ[$past(wrIdx)]);

  // R7: an adjacent redirect clears a matching entry
  assert_seq_clears_R7: assert property (@(posedge clk) disable iff (!rstN)
    (trainEn && sequential && wrMatch) |=> !validQ[$past(wrIdx)]);

  // R7: an entry that belongs to another line survives
  assert_alias_kept_R7: assert property (@(posedge clk) disable iff (!rstN)
    (trainEn && sequential && !wrMatch && validQ[wrIdx]) |=> validQ[$past(wrIdx)]);
endmodule

// File: rtl/fetchCtl.sv
module fetchCtl
  import fetchPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        restartValid,
  input  logic        cmdReady,
  input  logic        rspValid,
  input  logic        lineMatch,
  input  logic        bndReady,
  output logic        cmdValid,
  output logic        rspReady,
  output logic        bndValid,
  output fetchStrobeT strobe
);
  logic pendingQ;
  logic deliver;

  always_comb begin
    cmdValid           = !pendingQ && !restartValid;
    deliver            = pendingQ && rspValid && lineMatch && !restartValid;
    bndValid           = deliver;
    rspReady           = !deliver || bndReady;
    strobe.takeRestart = restartValid;
    strobe.advance     = deliver && bndReady;
    strobe.issue       = cmdValid && cmdReady;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                   pendingQ <= 1'b0;
    else if (strobe.takeRestart) pendingQ <= 1'b0;
    else if (strobe.issue)       pendingQ <= 1'b1;
    else if (strobe.advance)     pendingQ <= 1'b0;
  end

  assert_single_outstanding_R1: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdReady) |=> !cmdValid);

  assert_restart_quiet_R5: assert property (@(posedge clk) disable iff (!rstN)
    restartValid |-> (!cmdValid && !bndValid));

  assert_stray_dropped_R8: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !pendingQ) |-> (rspReady && !bndValid));

  assert_stall_holds_R9: assert property (@(posedge clk) disable iff (!rstN)
    (bndValid && !bndReady) |=> !cmdValid);
endmodule

// File: rtl/fetchDp.sv
module fetchDp
  import fetchPkg::*;
#(
  parameter int LINE_W = 16,
  parameter int GEN_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  fetchStrobeT       strobe,
  input  logic [GEN_W-1:0]  restartGen,
  input  logic [LINE_W-1:0] restartNewLine,
  input  logic [LINE_W-1:0] rspLine,
  input  logic              tblHit,
  input  logic [LINE_W-1:0] tblTarget,
  output logic [LINE_W-1:0] curLine,
  output logic [LINE_W-1:0] predLine,
  output logic [GEN_W-1:0]  gen,
  output logic              lineMatch
);
  localparam logic [LINE_W-1:0] ONE = LINE_W'(1);

  logic [LINE_W-1:0] curLineQ;
  logic [GEN_W-1:0]  genQ;

  always_comb begin
    curLine   = curLineQ;
    gen       = genQ;
    predLine  = tblHit ? tblTarget : curLineQ + ONE;
    lineMatch = (rspLine == curLineQ);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curLineQ <= '0;
      genQ     <= '0;
    end else if (strobe.takeRestart) begin
      curLineQ <= restartNewLine;
      genQ     <= restartGen;
    end else if (strobe.advance) begin
      curLineQ <= predLine;
    end
  end

  assert_restart_loads_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.takeRestart |=> (curLine == $past(restartNewLine) && gen == $past(restartGen)));

  assert_advance_follows_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.advance && !strobe.takeRestart) |=> (curLine == $past(predLine)));

  assert_line_steady_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.advance && !strobe.takeRestart) |=> $stable(curLine));
endmodule

// File: rtl/lineFetcher.sv
module lineFetcher
  import fetchPkg::*;
#(
  parameter int LINE_W      = 16,
  parameter int DATA_W      = 128,
  parameter int GEN_W       = 4,
  parameter int TBL_ENTRIES = 16
) (
  input  logic              clk,
  input  logic              rstN,
  output logic              cmdValid,
  input  logic              cmdReady,
  output logic [LINE_W-1:0] cmdLine,
  input  logic              rspValid,
  output logic              rspReady,
  input  logic [LINE_W-1:0] rspLine,
  input  logic [DATA_W-1:0] rspData,
  output logic              bndValid,
  input  logic              bndReady,
  output logic [GEN_W-1:0]  bndGen,
  output logic [LINE_W-1:0] bndLine,
  output logic [LINE_W-1:0] bndNextLine,
  output logic [DATA_W-1:0] bndData,
  input  logic              restartValid,
  input  logic [GEN_W-1:0]  restartGen,
  input  logic [LINE_W-1:0] restartPrevLine,
  input  logic [LINE_W-1:0] restartNewLine
);
  fetchStrobeT       strobe;
  logic              lineMatch, tblHit;
  logic [LINE_W-1:0] tblTarget, curLine, predLine;
  logic [GEN_W-1:0]  gen;

  fetchCtl uCtl (
    .clk, .rstN, .restartValid, .cmdReady, .rspValid, .lineMatch, .bndReady,
    .cmdValid, .rspReady, .bndValid, .strobe
  );

  fetchDp #(.LINE_W(LINE_W), .GEN_W(GEN_W)) uDp (
    .clk, .rstN, .strobe, .restartGen, .restartNewLine, .rspLine,
    .tblHit, .tblTarget, .curLine, .predLine, .gen, .lineMatch
  );

  nextLineTable #(.LINE_W(LINE_W), .TBL_ENTRIES(TBL_ENTRIES)) uTbl (
    .clk, .rstN, .lookupLine(curLine), .hit(tblHit), .target(tblTarget),
    .trainEn(strobe.takeRestart), .trainPrev(restartPrevLine), .trainNew(restartNewLine)
  );

  assign cmdLine     = curLine;
  assign bndLine     = curLine;
  assign bndNextLine = predLine;
  assign bndGen      = gen;
  assign bndData     = rspData;

  assert_bundle_matches_R3: assert property (@(posedge clk) disable iff (!rstN)
    bndValid |-> (rspValid && bndLine == rspLine && bndData == rspData));
endmodule

// File: tb/lineFetcher_bench.sv
module lineFetcher_bench;
  localparam int LW = 16;
  localparam int DW = 128;
  localparam int GW = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cmdValid, cmdReady = 1'b0;
  logic [LW-1:0] cmdLine;
  logic          rspValid = 1'b0, rspReady;
  logic [LW-1:0] rspLine = '0;
  logic [DW-1:0] rspData = '0;
  logic          bndValid, bndReady = 1'b1;
  logic [GW-1:0] bndGen;
  logic [LW-1:0] bndLine, bndNextLine;
  logic [DW-1:0] bndData;
  logic          restartValid = 1'b0;
  logic [GW-1:0] restartGen = '0;
  logic [LW-1:0] restartPrevLine = '0, restartNewLine = '0;

  int total = 0;
  int bad = 0;
  logic [GW-1:0] curGen = '0;

  always #5 clk = ~clk;

  lineFetcher u_lineFetcher (
    .clk, .rstN, .cmdValid, .cmdReady, .cmdLine, .rspValid, .rspReady, .rspLine,
    .rspData, .bndValid, .bndReady, .bndGen, .bndLine, .bndNextLine, .bndData,
    .restartValid, .restartGen, .restartPrevLine, .restartNewLine
  );

  function automatic logic [DW-1:0] dataFor(input logic [LW-1:0] l);
    return {4{l, ~l}};
  endfunction

  task automatic chk(input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic stepToNeg();
    @(posedge clk);
    @(negedge clk);
  endtask

  // restart cycle; called at a falling edge
  task automatic doRestart(input logic [LW-1:0] prev, input logic [LW-1:0] nw);
    curGen          = curGen + 1'b1;
    restartValid    = 1'b1;
    restartGen      = curGen;
    restartPrevLine = prev;
    restartNewLine  = nw;
    #1;
    chk("R5 cmdValid low during restart", cmdValid, 0);
    chk("R5 bndValid low during restart", bndValid, 0);
    stepToNeg();
    restartValid = 1'b0;
    #1;
    chk("R5 line loaded", cmdLine, nw);
    chk("R5 generation loaded", bndGen, curGen);
    chk("R2 request after restart", cmdValid, 1);
  endtask

  // one complete fetch; called at a falling edge
  task automatic fetchOne(input logic [LW-1:0] expLine, input logic [LW-1:0] expNext);
    #1;
    chk("R2 cmdValid", cmdValid, 1);
    chk("R2 cmdLine", cmdLine, expLine);
    cmdReady = 1'b1;
    stepToNeg();
    cmdReady = 1'b0;
    #1;
    chk("R1 no second request", cmdValid, 0);
    rspValid = 1'b1;
    rspLine  = expLine;
    rspData  = dataFor(expLine);
    bndReady = 1'b1;
    #1;
    chk("R3 bndValid", bndValid, 1);
    chk("R3 bndLine", bndLine, expLine);
    chk("R3 bndGen", bndGen, curGen);
    chk("R3 bndData", bndData, dataFor(expLine));
    chk("R4 bndNextLine", bndNextLine, expNext);
    stepToNeg();
    rspValid = 1'b0;
    #1;
    chk("R4 next request line", cmdLine, expNext);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    // R10: reset state
    chk("R10 cmdValid after reset", cmdValid, 1);
    chk("R10 cmdLine after reset", cmdLine, 0);
    chk("R10 generation after reset", bndGen, 0);
    chk("R10 no bundle after reset", bndValid, 0);

    // R8: response with no read pending
    rspValid = 1'b1; rspLine = '0; rspData = dataFor('0);
    #1;
    chk("R8 stray consumed", rspReady, 1);
    chk("R8 stray no bundle", bndValid, 0);
    stepToNeg();
    rspValid = 1'b0;
    #1;
    chk("R8 line unchanged by stray", cmdLine, 0);
    cmdReady = 1'b1;
    stepToNeg();
    cmdReady = 1'b0;
    // R8: mismatched line while pending
    rspValid = 1'b1; rspLine = 16'd9; rspData = dataFor(16'd9);
    #1;
    chk("R8 mismatch no bundle", bndValid, 0);
    chk("R8 mismatch consumed", rspReady, 1);
    stepToNeg();
    // R9: matching response stalled downstream
    rspLine = '0; rspData = dataFor('0); bndReady = 1'b0;
    #1;
    chk("R9 bundle offered", bndValid, 1);
    chk("R9 response held", rspReady, 0);
    stepToNeg();
    #1;
    chk("R9 still pending", cmdValid, 0);
    chk("R9 still offered", bndValid, 1);
    chk("R9 line kept", bndLine, 0);
    bndReady = 1'b1;
    #1;
    chk("R9 released", rspReady, 1);
    stepToNeg();
    rspValid = 1'b0;
    #1;
    chk("R4 sequential after stall", cmdLine, 1);

    // R4: sequential run on an empty table
    for (int i = 1; i <= 5; i++) fetchOne(LW'(i), LW'(i + 1));

    // R6: train 5 -> 0x40, then 0x41 -> 5
    doRestart(16'h0005, 16'h0040);
    fetchOne(16'h0040, 16'h0041);
    fetchOne(16'h0041, 16'h0042);
    doRestart(16'h0041, 16'h0005);
    fetchOne(16'h0005, 16'h0040);
    fetchOne(16'h0040, 16'h0041);
    fetchOne(16'h0041, 16'h0005);

    // R6: same slot, different tag misses
    doRestart(16'h0014, 16'h0015);
    fetchOne(16'h0015, 16'h0016);
    // R7: adjacent redirect from an aliasing line keeps the entry for 5
    doRestart(16'h0015, 16'h0016);
    fetchOne(16'h0016, 16'h0017);
    doRestart(16'h0017, 16'h0005);
    fetchOne(16'h0005, 16'h0040);
    // R7: same-line restart erases the entry for 5
    doRestart(16'h0005, 16'h0005);
    fetchOne(16'h0005, 16'h0006);

    // R5: restart together with the matching response cancels it
    #1;
    cmdReady = 1'b1;
    stepToNeg();
    cmdReady = 1'b0;
    rspValid = 1'b1; rspLine = 16'h0006; rspData = dataFor(16'h0006);
    doRestart(16'h0006, 16'h0080);
    // late response for the cancelled read
    #1;
    chk("R5 late response dropped", bndValid, 0);
    chk("R8 late response consumed", rspReady, 1);
    stepToNeg();
    rspValid = 1'b0;
    fetchOne(16'h0080, 16'h0081);

    // R4: wrap at the top of the line space
    doRestart(16'h0003, 16'hFFFF);
    fetchOne(16'hFFFF, 16'h0000);

    // R6: sweep every slot
    for (int i = 0; i < 16; i++) doRestart(LW'(16'h0100 + i), LW'(16'h0200 + 3 * i));
    for (int i = 0; i < 16; i++) begin
      doRestart(LW'(16'h00FF + i), LW'(16'h0100 + i));
      fetchOne(LW'(16'h0100 + i), LW'(16'h0200 + 3 * i));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule